// File: doc/BRIEF.md
# Phase-Frequency Detector with Lock Indicator

This block compares two digital edge streams: a divided reference (`ref_in`) and a divided oscillator feedback (`vco_in`). Both are sampled by a fast system clock. A rising edge on either stream sets one of two internal flags: "up" for the reference and "dn" for the feedback. Once both flags are set, they are held together for a programmable number of system clocks before both clear. This forced overlap ensures that even a zero phase error produces a short simultaneous pulse, so the detector has no dead zone.

The flags are steered onto three kinds of output:

- A pair of active-low pump signals.
- A single-ended three-state error output, given as a drive value plus an output enable.
- A lock indicator.

A six-bit control register, loaded by a write strobe, sets the following:

- Pump polarity.
- Enables for each output.
- Interchange of the pump pair.
- Inversion of the error output.

Reset clears the control register. The lock indicator therefore stays low, and no false lock is reported, until software enables it.

Top module: `pfd_lock_top`

## Requirements
- R1: After reset, `pump_r_n` and `pump_v_n` are high, `err_oe` and `err_drive` are low, and `lock_out` is low. These values hold while any input edges arrive, until the control register is written.
- R2: When `ctrl_wr` is high on a clock edge, the control register loads `ctrl_wdata`; otherwise it holds its value. The field positions are:
  - bit 0: polarity
  - bit 1: pump enable
  - bit 2: pump interchange
  - bit 3: error-output enable
  - bit 4: error-output invert
  - bit 5: lock enable
- R3: A rising edge on `ref_in` sets the up flag, and a rising edge on `vco_in` sets the dn flag. An input change set up before clock edge k first shows at the outputs after edge k+2.
- R4: When both flags are set, they stay set for exactly MIN_OVL clocks (default 2) and then clear together.
- R5: With polarity 0 and pumps enabled, `pump_r_n` is low while only up is set, and `pump_v_n` is low while only dn is set.
- R6: With polarity 1 and pumps enabled, the two pump roles swap: `pump_v_n` follows up and `pump_r_n` follows dn.
- R7: During the forced overlap, both pump outputs are low together and `err_oe` is low.
- R8: With the error output enabled, `err_oe` is high exactly when one flag is set. `err_drive` is then:
  - for polarity 0: 1 when up is set and 0 when dn is set;
  - for polarity 1: 0 when up is set and 1 when dn is set.

  `err_drive` is 0 whenever `err_oe` is low, and a disabled error output keeps `err_oe` low.
- R9: The error-invert bit complements `err_drive` while `err_oe` is high.
- R10: With pumps disabled, both pump outputs stay high. The interchange bit exchanges the two pump outputs.
- R11: With lock enabled, `lock_out` is low while any flag is set and high otherwise. With lock disabled, `lock_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ref_in | input | 1 | Divided reference edge stream |
| vco_in | input | 1 | Divided oscillator edge stream |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 6 | Control register write data |
| pump_r_n | output | 1 | Active-low reference-side pump output |
| pump_v_n | output | 1 | Active-low oscillator-side pump output |
| err_drive | output | 1 | Single-ended error drive value |
| err_oe | output | 1 | Single-ended error output enable (low = high impedance) |
| lock_out | output | 1 | Lock indicator |

## Verification
The assertions check two things on every cycle:

- A flag only rises after a detected input edge, an edge pulse never lasts two cycles, and an expired overlap always clears both flags unless a new edge arrives.
- The error output never drives during an overlap, and lock is never high while the error output drives.

The bench scenarios cover the rest:

- The three-edge latency, the exact overlap length, and the pump and error mappings for each polarity, interchange, invert and enable setting.
- The held-low lock after reset and a control write that is ignored when `ctrl_wr` is low.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  localparam int CTRL_W = 6;

  typedef struct packed {
    logic lock_en;
    logic err_inv;
    logic err_en;
    logic pump_swap;
    logic pump_en;
    logic pol;
  } pfd_ctrl_t;
endpackage

// File: rtl/pfd_rst_sync.sv
module pfd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pfd_edge_det.sv
module pfd_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   prev_q, prev_d;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], din};
    prev_d = sync_q[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;

  // R3: a detected edge is a single-cycle pulse
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/pfd_core.sv
module pfd_core #(
  parameter int MIN_OVL = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_r,
  input  logic rise_v,
  output logic up,
  output logic dn
);
  localparam int CNT_W = (MIN_OVL > 1) ? $clog2(MIN_OVL) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MIN_OVL - 1);

  logic             up_q, up_d, dn_q, dn_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             both, done;

  always_comb begin
    both  = up_q & dn_q;
    done  = both && (cnt_q == LAST);
    up_d  = (up_q & ~done) | rise_r;
    dn_d  = (dn_q & ~done) | rise_v;
    cnt_d = (both && !done) ? cnt_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q  <= 1'b0;
      dn_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      up_q  <= up_d;
      dn_q  <= dn_d;
      cnt_q <= cnt_d;
    end
  end

  assign up = up_q;
  assign dn = dn_q;

  // R3: flags only rise after a detected input edge
  a_r3_up_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(up_q) |-> $past(rise_r));
  a_r3_dn_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dn_q) |-> $past(rise_v));
  // R4: an expired overlap clears both flags unless a new edge arrives
  a_r4_overlap_end: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && dn_q && cnt_q == LAST) |=>
      ((!up_q || $past(rise_r)) && (!dn_q || $past(rise_v))));
endmodule

// File: rtl/pfd_steer.sv
module pfd_steer
  import pfd_pkg::*;
(
  input  pfd_ctrl_t ctrl,
  input  logic      up,
  input  logic      dn,
  output logic      pump_r_n,
  output logic      pump_v_n,
  output logic      err_drive,
  output logic      err_oe,
  output logic      lock_out
);
  logic r_act, v_act, one_act, raw_drv;

  always_comb begin
    r_act = ctrl.pol ? dn : up;
    v_act = ctrl.pol ? up : dn;
    if (!ctrl.pump_en) begin
      pump_r_n = 1'b1;
      pump_v_n = 1'b1;
    end else if (ctrl.pump_swap) begin
      pump_r_n = ~v_act;
      pump_v_n = ~r_act;
    end else begin
      pump_r_n = ~r_act;
      pump_v_n = ~v_act;
    end
    one_act   = up ^ dn;
    raw_drv   = ctrl.pol ? dn : up;
    err_oe    = ctrl.err_en & one_act;
    err_drive = err_oe & (raw_drv ^ ctrl.err_inv);
    lock_out  = ctrl.lock_en & ~(up | dn);
  end
endmodule

// File: rtl/pfd_lock_top.sv
module pfd_lock_top
  import pfd_pkg::*;
#(
  parameter int MIN_OVL     = 2,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_in,
  input  logic              vco_in,
  input  logic              ctrl_wr,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  output logic              pump_r_n,
  output logic              pump_v_n,
  output logic              err_drive,
  output logic              err_oe,
  output logic              lock_out
);
  localparam int N_IN = 2;

  logic            rst_sync_n;
  logic [N_IN-1:0] in_vec, rise_vec;
  pfd_ctrl_t       ctrl_q, ctrl_d;
  logic            up, dn;

  pfd_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  assign in_vec = {vco_in, ref_in};

  for (genvar i = 0; i < N_IN; i++) begin : g_edge
    pfd_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_sync_n), .din(in_vec[i]), .rise(rise_vec[i])
    );
  end

  always_comb begin
    ctrl_d = ctrl_wr ? pfd_ctrl_t'(ctrl_wdata) : ctrl_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) ctrl_q <= '0;
    else             ctrl_q <= ctrl_d;
  end

  pfd_core #(.MIN_OVL(MIN_OVL)) u_core (
    .clk(clk), .rst_n(rst_sync_n),
    .rise_r(rise_vec[0]), .rise_v(rise_vec[1]),
    .up(up), .dn(dn)
  );

  pfd_steer u_steer (
    .ctrl(ctrl_q), .up(up), .dn(dn),
    .pump_r_n(pump_r_n), .pump_v_n(pump_v_n),
    .err_drive(err_drive), .err_oe(err_oe), .lock_out(lock_out)
  );

  // R7: both pumps low together means the single-ended output floats
  a_r7_overlap_hiz: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!pump_r_n && !pump_v_n) |-> !err_oe);
  // R11: lock never reported while the error output drives
  a_r11_lock_quiet: assert property (@(posedge clk) disable iff (!rst_sync_n)
    err_oe |-> !lock_out);
  // R8: a driven value only appears with the output enabled
  a_r8_drive_gated: assert property (@(posedge clk) disable iff (!rst_sync_n)
    err_drive |-> err_oe);
endmodule

// File: tb/pfd_lock_top_tb.sv
`timescale 1ns/1ps
module pfd_lock_top_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ref_in, vco_in, ctrl_wr;
  logic [5:0] ctrl_wdata;
  logic       pump_r_n, pump_v_n, err_drive, err_oe, lock_out;
  int         n_chk = 0;
  int         n_fail = 0;
  logic       finished = 1'b0;

  always #4 clk = ~clk;

  pfd_lock_top u_dut (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .vco_in(vco_in),
    .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .pump_r_n(pump_r_n), .pump_v_n(pump_v_n),
    .err_drive(err_drive), .err_oe(err_oe), .lock_out(lock_out)
  );

  // vector: {ctrl[5:0], ref_at[3:0], vco_at[3:0], obs[3:0], exp{pr,pv,oe,drv,lock}}
  localparam int NV = 15;
  localparam logic [22:0] VEC [NV] = '{
    {6'h2A, 4'd0, 4'd5, 4'd4, 5'b01110},  // R5 up only, pol 0
    {6'h2A, 4'd5, 4'd0, 4'd4, 5'b10100},  // R5 dn only, pol 0
    {6'h2B, 4'd0, 4'd5, 4'd4, 5'b10100},  // R6 up only, pol 1
    {6'h2B, 4'd5, 4'd0, 4'd4, 5'b01110},  // R6 dn only, pol 1
    {6'h2A, 4'd0, 4'd0, 4'd3, 5'b00000},  // R7 overlap first cycle
    {6'h2A, 4'd0, 4'd0, 4'd4, 5'b00000},  // R4 overlap second cycle
    {6'h2A, 4'd0, 4'd0, 4'd5, 5'b11001},  // R4 cleared after MIN_OVL
    {6'h2E, 4'd0, 4'd5, 4'd4, 5'b10110},  // R10 interchange
    {6'h3A, 4'd0, 4'd5, 4'd4, 5'b01100},  // R9 invert
    {6'h22, 4'd0, 4'd5, 4'd4, 5'b01000},  // R8 error disabled
    {6'h28, 4'd0, 4'd5, 4'd4, 5'b11110},  // R10 pumps disabled
    {6'h0A, 4'd0, 4'd0, 4'd5, 5'b11000},  // R11 lock disabled
    {6'h2A, 4'd0, 4'd4, 4'd7, 5'b00000},  // R4 late dn opens overlap
    {6'h2A, 4'd0, 4'd4, 4'd9, 5'b11001},  // R11 lock back after overlap
    {6'h2A, 4'd0, 4'd4, 4'd2, 5'b11001}   // R3 no change before edge k+2
  };
  localparam string VREQ [NV] = '{"R5", "R5", "R6", "R6", "R7", "R4", "R4",
                                  "R10", "R9", "R8", "R10", "R11", "R4", "R11", "R3"};

  function automatic logic [4:0] outs();
    return {pump_r_n, pump_v_n, err_oe, err_drive, lock_out};
  endfunction

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: outputs {pr,pv,oe,drv,lock} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic write_ctrl(input logic [5:0] v);
    @(negedge clk);
    ctrl_wr    = 1'b1;
    ctrl_wdata = v;
    @(negedge clk);
    ctrl_wr    = 1'b0;
  endtask

  // drive ref/vco high from given iterations; check at iteration obs
  task automatic run_edges(input int ra, input int va, input int obs,
                           input string req, input logic [4:0] exp);
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      if (c == obs) check(req, outs(), exp);
      ref_in = (c >= ra);
      vco_in = (c >= va);
    end
    ref_in = 1'b0;
    vco_in = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; ref_in = 1'b0; vco_in = 1'b0;
    ctrl_wr = 1'b0; ctrl_wdata = '0;
    repeat (3) @(negedge clk);
    check("R1", outs(), 5'b11000);            // R1 during reset
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", outs(), 5'b11000);            // R1 after release
    // R1: edges before any control write change nothing at the ports
    run_edges(0, 5, 4, "R1", 5'b11000);
    run_edges(0, 0, 3, "R1", 5'b11000);

    for (int i = 0; i < NV; i++) begin
      write_ctrl(VEC[i][22:17]);
      run_edges(int'(VEC[i][16:13]), int'(VEC[i][12:9]), int'(VEC[i][8:5]),
                VREQ[i], VEC[i][4:0]);
    end

    // R2: data without a write strobe is ignored (polarity stays 0)
    write_ctrl(6'h2A);
    @(negedge clk);
    ctrl_wdata = 6'h2B;
    run_edges(0, 5, 4, "R2", 5'b01110);
    // R2: a strobed write takes effect
    write_ctrl(6'h2B);
    run_edges(0, 5, 4, "R2", 5'b10100);
    // R11: idle and enabled shows lock
    check("R11", outs(), 5'b11001);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule